// File: doc/BRIEF.md
# Region Protection Lookaside Buffer

This block holds a small, fully associative set of memory-protection region descriptors and is consulted on every load, store, fetch and protected call made by a core that has no privilege modes. Each descriptor names an inclusive byte range, a set of granted access kinds, and the owner it applies to: a thread id plus either one turf id or any turf. A lookup presents an address, an access kind and the current turf and thread ids. One cycle later the buffer answers allow, deny or miss. A miss sends the core to a table walk outside this block.

Software adds descriptors through an insert port and removes them by slot index. Descriptors built on chip are marked as locally created (novel), because the protection table in memory does not yet hold them. When an insert finds every slot occupied, it evicts a victim in round-robin order. A novel victim is handed out on a writeback port so that it can be stored in the table. Revoking a descriptor that the table already holds only clears it in place. A counter tracks how many of these in-place revocations still wait for a single batched table update. That update acknowledges the count and clears it.

Top module: `rgn_guard_buf`

## Requirements
- R1: After reset every slot is empty. Every lookup answers miss (result code 0), `stale_count_o` is 0, and `wb_valid_o`, `ins_done_o` and `ins_reject_o` are low.
- R2: A lookup is answered exactly one cycle after `lk_req`, with `lk_valid_o` high for that one cycle. The answer is allow (code 1) when some valid slot matches the ids, covers the address and grants the access kind. Access kind codes: 0 read, 1 write, 2 execute, 3 protected call. Permission bits: bit0 read, bit1 write, bit2 execute, bit3 protected call.
- R3: The answer is deny (code 2) when at least one valid slot matches the ids and covers the address, but none of those slots grants the access kind.
- R4: The answer is miss (code 0) when no valid slot both matches the ids and covers the address. Both bounds are inclusive and are compared at byte granularity.
- R5: A slot whose any-turf flag is set matches every turf id. The thread id must still be equal.
- R6: An insert that asks for both execute and protected-call permission is rejected. `ins_reject_o` pulses one cycle later, `ins_done_o` stays low, and no slot changes.
- R7: An accepted insert fills the lowest-numbered empty slot. `ins_done_o` pulses one cycle later with that slot on `ins_slot_o`.
- R8: When no slot is empty, an accepted insert replaces the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each eviction. If the victim was novel, its bounds, permissions and ids appear on the writeback port for one cycle, one cycle after the insert. A victim that is not novel produces no writeback.
- R9: Revoking an occupied slot empties it. If that slot was not novel, `stale_count_o` rises by one on the next cycle and saturates at its maximum. Revoking a novel slot or an empty slot leaves the count unchanged.
- R10: `stale_ack` clears the count to 0. If a counted revocation happens in the same cycle, the count becomes 1 instead.
- R11: A revoke and an insert in the same cycle are both applied. The revoked slot is treated as empty for the insert's slot choice, so on a full buffer the insert takes the revoked slot and produces no writeback. A lookup that arrives in the same cycle as either one is judged on the contents from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Byte address checked |
| lk_kind | input | 2 | Access kind code |
| lk_turf | input | ID_W | Current turf id |
| lk_thread | input | ID_W | Current thread id |
| lk_valid_o | output | 1 | Lookup answer valid |
| lk_result_o | output | 2 | 0 miss, 1 allow, 2 deny |
| ins_req | input | 1 | Insert request |
| ins_lo | input | ADDR_W | Lowest covered byte |
| ins_hi | input | ADDR_W | Highest covered byte |
| ins_perm | input | 4 | Requested permissions |
| ins_turf | input | ID_W | Owner turf id |
| ins_thread | input | ID_W | Owner thread id |
| ins_turf_any | input | 1 | Match every turf |
| ins_novel | input | 1 | Descriptor created locally, not in table |
| ins_done_o | output | 1 | Insert accepted |
| ins_reject_o | output | 1 | Insert refused |
| ins_slot_o | output | IDX_W | Slot written by the accepted insert |
| rv_req | input | 1 | Revoke request |
| rv_idx | input | IDX_W | Slot to revoke |
| stale_ack | input | 1 | Batched table update finished |
| stale_count_o | output | CNT_W | Clean revocations awaiting table update |
| wb_valid_o | output | 1 | Evicted novel descriptor presented |
| wb_lo_o | output | ADDR_W | Evicted lower bound |
| wb_hi_o | output | ADDR_W | Evicted upper bound |
| wb_perm_o | output | 4 | Evicted permissions |
| wb_turf_o | output | ID_W | Evicted turf id |
| wb_thread_o | output | ID_W | Evicted thread id |
| wb_turf_any_o | output | 1 | Evicted any-turf flag |

## Verification
The two functions that can land in one cycle are the insert and the revoke. On a full buffer, the revoke decides which slot the insert takes and whether any writeback appears at all. The bench first fills all slots and then issues a revoke and an insert together. It expects the insert on the revoked index, no writeback, and a stale-count step only if the revoked slot was clean. A lookup sent in that same cycle must still see the old contents. Random mixes of all four operations then recreate these overlaps many times against a bench model that applies the same ordering.

// File: rtl/rgn_guard_pkg.sv
package rgn_guard_pkg;

  // access kind codes presented with a lookup
  typedef enum logic [1:0] {
    ACC_READ   = 2'd0,
    ACC_WRITE  = 2'd1,
    ACC_EXEC   = 2'd2,
    ACC_PORTAL = 2'd3
  } acc_kind_e;

  // lookup answer codes
  typedef enum logic [1:0] {
    RES_MISS  = 2'd0,
    RES_ALLOW = 2'd1,
    RES_DENY  = 2'd2
  } lk_res_e;

  // permission set, bit0 read ... bit3 protected call
  typedef struct packed {
    logic pt;
    logic ex;
    logic wr;
    logic rd;
  } perm_t;

  function automatic logic perm_allows(perm_t p, logic [1:0] kind);
    case (kind)
      2'd0:    return p.rd;
      2'd1:    return p.wr;
      2'd2:    return p.ex;
      default: return p.pt;
    endcase
  endfunction

  // execute and protected call may not share a descriptor
  function automatic logic perm_legal(perm_t p);
    return !(p.ex && p.pt);
  endfunction

  function automatic lk_res_e classify(logic covered, logic granted);
    if (granted)      return RES_ALLOW;
    else if (covered) return RES_DENY;
    else              return RES_MISS;
  endfunction

  function automatic logic in_range(logic [63:0] a, logic [63:0] lo, logic [63:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/rgn_entry_store.sv
module rgn_entry_store
  import rgn_guard_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int ID_W    = 22
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ENTRIES-1:0]              we,
  input  logic [ENTRIES-1:0]              clr,
  input  logic [ADDR_W-1:0]               w_lo,
  input  logic [ADDR_W-1:0]               w_hi,
  input  perm_t                           w_perm,
  input  logic [ID_W-1:0]                 w_turf,
  input  logic [ID_W-1:0]                 w_thread,
  input  logic                            w_any,
  input  logic                            w_novel,
  output logic [ENTRIES-1:0]              valid,
  output logic [ENTRIES-1:0]              novel,
  output logic [ENTRIES-1:0][ADDR_W-1:0]  lo,
  output logic [ENTRIES-1:0][ADDR_W-1:0]  hi,
  output perm_t [ENTRIES-1:0]             perm,
  output logic [ENTRIES-1:0][ID_W-1:0]    turf,
  output logic [ENTRIES-1:0][ID_W-1:0]    thread,
  output logic [ENTRIES-1:0]              any
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid[i]  <= 1'b0;
        novel[i]  <= 1'b0;
        lo[i]     <= '0;
        hi[i]     <= '0;
        perm[i]   <= '0;
        turf[i]   <= '0;
        thread[i] <= '0;
        any[i]    <= 1'b0;
      end else if (we[i]) begin
        // a write wins over a same-cycle clear of this slot
        valid[i]  <= 1'b1;
        novel[i]  <= w_novel;
        lo[i]     <= w_lo;
        hi[i]     <= w_hi;
        perm[i]   <= w_perm;
        turf[i]   <= w_turf;
        thread[i] <= w_thread;
        any[i]    <= w_any;
      end else if (clr[i]) begin
        valid[i]  <= 1'b0;
        novel[i]  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rgn_match_unit.sv
module rgn_match_unit
  import rgn_guard_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int ID_W    = 22
) (
  input  logic [ADDR_W-1:0]               addr,
  input  logic [1:0]                      kind,
  input  logic [ID_W-1:0]                 cur_turf,
  input  logic [ID_W-1:0]                 cur_thread,
  input  logic [ENTRIES-1:0]              valid,
  input  logic [ENTRIES-1:0][ADDR_W-1:0]  lo,
  input  logic [ENTRIES-1:0][ADDR_W-1:0]  hi,
  input  perm_t [ENTRIES-1:0]             perm,
  input  logic [ENTRIES-1:0][ID_W-1:0]    turf,
  input  logic [ENTRIES-1:0][ID_W-1:0]    thread,
  input  logic [ENTRIES-1:0]              any,
  output logic [ENTRIES-1:0]              cover_vec,
  output logic [ENTRIES-1:0]              grant_vec
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic id_ok;
    logic span_ok;
    always_comb begin
      id_ok   = (thread[i] == cur_thread) && (any[i] || (turf[i] == cur_turf));
      span_ok = in_range(64'(addr), 64'(lo[i]), 64'(hi[i]));
      cover_vec[i] = valid[i] && id_ok && span_ok;
      grant_vec[i] = cover_vec[i] && perm_allows(perm[i], kind);
    end
  end

endmodule

// File: rtl/rgn_slot_alloc.sv
module rgn_slot_alloc #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] occupied,
  input  logic               take,
  output logic [IDX_W-1:0]   slot,
  output logic               full
);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;

  // lowest-numbered empty slot
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!occupied[i]) free_idx = IDX_W'(i);
    end
  end

  assign full = &occupied;
  assign slot = full ? rr_q : free_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (take && full) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

endmodule

// File: rtl/rgn_guard_buf.sv
module rgn_guard_buf
  import rgn_guard_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int ID_W    = 22,
  parameter int CNT_W   = 6,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [1:0]        lk_kind,
  input  logic [ID_W-1:0]   lk_turf,
  input  logic [ID_W-1:0]   lk_thread,
  output logic              lk_valid_o,
  output logic [1:0]        lk_result_o,
  input  logic              ins_req,
  input  logic [ADDR_W-1:0] ins_lo,
  input  logic [ADDR_W-1:0] ins_hi,
  input  logic [3:0]        ins_perm,
  input  logic [ID_W-1:0]   ins_turf,
  input  logic [ID_W-1:0]   ins_thread,
  input  logic              ins_turf_any,
  input  logic              ins_novel,
  output logic              ins_done_o,
  output logic              ins_reject_o,
  output logic [IDX_W-1:0]  ins_slot_o,
  input  logic              rv_req,
  input  logic [IDX_W-1:0]  rv_idx,
  input  logic              stale_ack,
  output logic [CNT_W-1:0]  stale_count_o,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_lo_o,
  output logic [ADDR_W-1:0] wb_hi_o,
  output logic [3:0]        wb_perm_o,
  output logic [ID_W-1:0]   wb_turf_o,
  output logic [ID_W-1:0]   wb_thread_o,
  output logic              wb_turf_any_o
);

  // slot contents
  logic [ENTRIES-1:0]             e_valid;
  logic [ENTRIES-1:0]             e_novel;
  logic [ENTRIES-1:0][ADDR_W-1:0] e_lo;
  logic [ENTRIES-1:0][ADDR_W-1:0] e_hi;
  perm_t [ENTRIES-1:0]            e_perm;
  logic [ENTRIES-1:0][ID_W-1:0]   e_turf;
  logic [ENTRIES-1:0][ID_W-1:0]   e_thread;
  logic [ENTRIES-1:0]             e_any;

  // named internal events, also watched by the checker
  logic [ENTRIES-1:0] cover_vec;
  logic [ENTRIES-1:0] grant_vec;
  logic [ENTRIES-1:0] clr_vec;
  logic [ENTRIES-1:0] slot_we;
  logic [ENTRIES-1:0] occupied;
  logic [IDX_W-1:0]   pick;
  logic               all_full;
  logic               ins_ok;
  logic               ins_bad;
  logic               evict_fire;
  logic               evict_novel;
  logic               clean_revoke;

  perm_t req_perm;
  assign req_perm = perm_t'(ins_perm);

  // revoke first, so the insert may reuse the freed slot
  assign clr_vec      = rv_req ? (ENTRIES'(1) << rv_idx) : '0;
  assign occupied     = e_valid & ~clr_vec;
  assign ins_ok       = ins_req && perm_legal(req_perm);
  assign ins_bad      = ins_req && !perm_legal(req_perm);
  assign slot_we      = ins_ok ? (ENTRIES'(1) << pick) : '0;
  assign evict_fire   = ins_ok && all_full;
  assign evict_novel  = evict_fire && e_novel[pick];
  assign clean_revoke = rv_req && e_valid[rv_idx] && !e_novel[rv_idx];

  rgn_entry_store #(
    .ENTRIES (ENTRIES),
    .ADDR_W  (ADDR_W),
    .ID_W    (ID_W)
  ) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (slot_we),
    .clr      (clr_vec),
    .w_lo     (ins_lo),
    .w_hi     (ins_hi),
    .w_perm   (req_perm),
    .w_turf   (ins_turf),
    .w_thread (ins_thread),
    .w_any    (ins_turf_any),
    .w_novel  (ins_novel),
    .valid    (e_valid),
    .novel    (e_novel),
    .lo       (e_lo),
    .hi       (e_hi),
    .perm     (e_perm),
    .turf     (e_turf),
    .thread   (e_thread),
    .any      (e_any)
  );

  rgn_match_unit #(
    .ENTRIES (ENTRIES),
    .ADDR_W  (ADDR_W),
    .ID_W    (ID_W)
  ) match_i (
    .addr       (lk_addr),
    .kind       (lk_kind),
    .cur_turf   (lk_turf),
    .cur_thread (lk_thread),
    .valid      (e_valid),
    .lo         (e_lo),
    .hi         (e_hi),
    .perm       (e_perm),
    .turf       (e_turf),
    .thread     (e_thread),
    .any        (e_any),
    .cover_vec  (cover_vec),
    .grant_vec  (grant_vec)
  );

  rgn_slot_alloc #(
    .ENTRIES (ENTRIES)
  ) alloc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .occupied (occupied),
    .take     (ins_ok),
    .slot     (pick),
    .full     (all_full)
  );

  // lookup answer register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_valid_o  <= 1'b0;
      lk_result_o <= RES_MISS;
    end else begin
      lk_valid_o  <= lk_req;
      lk_result_o <= lk_req ? classify(|cover_vec, |grant_vec) : RES_MISS;
    end
  end

  // insert status
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ins_done_o   <= 1'b0;
      ins_reject_o <= 1'b0;
      ins_slot_o   <= '0;
    end else begin
      ins_done_o   <= ins_ok;
      ins_reject_o <= ins_bad;
      if (ins_ok) ins_slot_o <= pick;
    end
  end

  // writeback of a novel victim, taken from the contents before overwrite
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid_o    <= 1'b0;
      wb_lo_o       <= '0;
      wb_hi_o       <= '0;
      wb_perm_o     <= '0;
      wb_turf_o     <= '0;
      wb_thread_o   <= '0;
      wb_turf_any_o <= 1'b0;
    end else begin
      wb_valid_o <= evict_novel;
      if (evict_novel) begin
        wb_lo_o       <= e_lo[pick];
        wb_hi_o       <= e_hi[pick];
        wb_perm_o     <= e_perm[pick];
        wb_turf_o     <= e_turf[pick];
        wb_thread_o   <= e_thread[pick];
        wb_turf_any_o <= e_any[pick];
      end
    end
  end

  // deferred table update counter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stale_count_o <= '0;
    end else if (stale_ack) begin
      stale_count_o <= clean_revoke ? CNT_W'(1) : '0;
    end else if (clean_revoke && (stale_count_o != '1)) begin
      stale_count_o <= stale_count_o + 1'b1;
    end
  end

endmodule

// File: rtl/rgn_guard_chk.sv
module rgn_guard_chk #(
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_req,
  input logic               lk_valid_o,
  input logic [1:0]         lk_result_o,
  input logic               ins_req,
  input logic [3:0]         ins_perm,
  input logic               ins_done_o,
  input logic               ins_reject_o,
  input logic               wb_valid_o,
  input logic               evict_novel,
  input logic               clean_revoke,
  input logic               stale_ack,
  input logic [CNT_W-1:0]   stale_count_o,
  input logic [ENTRIES-1:0] slot_we
);

  p_answer_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_valid_o);

  p_answer_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> (!lk_valid_o && lk_result_o == 2'd0));

  p_code_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_result_o != 2'd3);

  p_reject_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && ins_perm[2] && ins_perm[3]) |=> (ins_reject_o && !ins_done_o));

  p_single_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we));

  p_wb_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> $past(evict_novel));

  p_stale_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stale_ack && !clean_revoke) |=> $stable(stale_count_o));

  p_stale_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stale_ack && !clean_revoke) |=> (stale_count_o == '0));

endmodule

bind rgn_guard_buf rgn_guard_chk #(
  .ENTRIES (ENTRIES),
  .CNT_W   (CNT_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .lk_req        (lk_req),
  .lk_valid_o    (lk_valid_o),
  .lk_result_o   (lk_result_o),
  .ins_req       (ins_req),
  .ins_perm      (ins_perm),
  .ins_done_o    (ins_done_o),
  .ins_reject_o  (ins_reject_o),
  .wb_valid_o    (wb_valid_o),
  .evict_novel   (evict_novel),
  .clean_revoke  (clean_revoke),
  .stale_ack     (stale_ack),
  .stale_count_o (stale_count_o),
  .slot_we       (slot_we)
);

// File: tb/rgn_guard_buf_tb_top.sv
module rgn_guard_buf_tb_top;

  localparam int N  = 16;
  localparam int AW = 32;
  localparam int IW = 22;
  localparam int CW = 6;
  localparam int XW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_req = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic [1:0]    lk_kind = '0;
  logic [IW-1:0] lk_turf = '0;
  logic [IW-1:0] lk_thread = '0;
  logic          lk_valid_o;
  logic [1:0]    lk_result_o;
  logic          ins_req = 1'b0;
  logic [AW-1:0] ins_lo = '0;
  logic [AW-1:0] ins_hi = '0;
  logic [3:0]    ins_perm = '0;
  logic [IW-1:0] ins_turf = '0;
  logic [IW-1:0] ins_thread = '0;
  logic          ins_turf_any = 1'b0;
  logic          ins_novel = 1'b0;
  logic          ins_done_o;
  logic          ins_reject_o;
  logic [XW-1:0] ins_slot_o;
  logic          rv_req = 1'b0;
  logic [XW-1:0] rv_idx = '0;
  logic          stale_ack = 1'b0;
  logic [CW-1:0] stale_count_o;
  logic          wb_valid_o;
  logic [AW-1:0] wb_lo_o;
  logic [AW-1:0] wb_hi_o;
  logic [3:0]    wb_perm_o;
  logic [IW-1:0] wb_turf_o;
  logic [IW-1:0] wb_thread_o;
  logic          wb_turf_any_o;

  always #5ns clk = ~clk;

  rgn_guard_buf dut_i (.*);

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench model of the slots
  bit            m_valid [N];
  bit            m_novel [N];
  logic [AW-1:0] m_lo    [N];
  logic [AW-1:0] m_hi    [N];
  logic [3:0]    m_perm  [N];
  logic [IW-1:0] m_turf  [N];
  logic [IW-1:0] m_thr   [N];
  bit            m_any   [N];
  int            m_rr = 0;
  int            m_stale = 0;

  // stimulus for the next cycle
  bit            d_lk, d_ins, d_rv, d_ack, d_novel, d_any;
  logic [AW-1:0] d_addr, d_lo, d_hi;
  logic [1:0]    d_kind;
  logic [IW-1:0] d_turf, d_thr, d_iturf, d_ithr;
  logic [3:0]    d_perm;
  int            d_rvidx;
  string         d_tag = "";

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected answer: 0 miss, 1 allow, 2 deny
  function automatic int exp_answer(logic [AW-1:0] a, logic [1:0] k,
                                    logic [IW-1:0] tu, logic [IW-1:0] th);
    bit cov = 0, gr = 0;
    for (int i = 0; i < N; i++) begin
      if (m_valid[i] && m_thr[i] == th && (m_any[i] || m_turf[i] == tu)
          && a >= m_lo[i] && a <= m_hi[i]) begin
        cov = 1;
        if (m_perm[i][k]) gr = 1;
      end
    end
    return gr ? 1 : (cov ? 2 : 0);
  endfunction

  task automatic tick();
    int  e_ans, slot, wslot;
    bit  legal, full, e_wb, clean;
    logic [AW-1:0] wlo, whi;
    logic [IW-1:0] wtu, wth;
    logic [3:0]    wpm;
    string tg;
    lk_req = d_lk; lk_addr = d_addr; lk_kind = d_kind; lk_turf = d_turf; lk_thread = d_thr;
    ins_req = d_ins; ins_lo = d_lo; ins_hi = d_hi; ins_perm = d_perm; ins_turf = d_iturf;
    ins_thread = d_ithr; ins_turf_any = d_any; ins_novel = d_novel;
    rv_req = d_rv; rv_idx = XW'(d_rvidx); stale_ack = d_ack;
    // model: lookup on old contents, revoke, then insert
    e_ans = exp_answer(d_addr, d_kind, d_turf, d_thr);
    clean = d_rv && m_valid[d_rvidx] && !m_novel[d_rvidx];
    if (d_rv) begin m_valid[d_rvidx] = 0; m_novel[d_rvidx] = 0; end
    legal = !(d_perm[2] && d_perm[3]);
    full = 1; slot = -1;
    for (int i = 0; i < N; i++) if (!m_valid[i] && slot < 0) begin slot = i; full = 0; end
    if (full) slot = m_rr;
    e_wb = d_ins && legal && full && m_novel[slot];
    wlo = m_lo[slot]; whi = m_hi[slot]; wtu = m_turf[slot]; wth = m_thr[slot]; wpm = m_perm[slot];
    wslot = slot;
    if (d_ins && legal) begin
      m_valid[slot] = 1; m_novel[slot] = d_novel; m_lo[slot] = d_lo; m_hi[slot] = d_hi;
      m_perm[slot] = d_perm; m_turf[slot] = d_iturf; m_thr[slot] = d_ithr; m_any[slot] = d_any;
      if (full) m_rr = (m_rr + 1) % N;
    end
    if (d_ack) m_stale = clean ? 1 : 0;
    else if (clean && m_stale < (1 << CW) - 1) m_stale++;
    @(negedge clk);
    tg = (d_tag != "") ? d_tag : (e_ans == 1 ? "R2" : (e_ans == 2 ? "R3" : "R4"));
    check("R2", lk_valid_o, d_lk);
    if (d_lk) check(tg, lk_result_o, e_ans);
    if (d_ins) begin
      check("R6", ins_reject_o, !legal);
      check("R7", ins_done_o, legal);
      if (legal) check(full ? "R8" : "R7", ins_slot_o, wslot);
    end
    check("R8", wb_valid_o, e_wb);
    if (e_wb) begin
      check("R8", wb_lo_o, wlo); check("R8", wb_hi_o, whi);
      check("R8", wb_turf_o, wtu); check("R8", wb_thread_o, wth); check("R8", wb_perm_o, wpm);
    end
    check(d_ack ? "R10" : "R9", stale_count_o, m_stale);
    d_lk = 0; d_ins = 0; d_rv = 0; d_ack = 0; d_tag = "";
  endtask

  task automatic set_lk(logic [AW-1:0] a, logic [1:0] k, logic [IW-1:0] tu, logic [IW-1:0] th);
    d_lk = 1; d_addr = a; d_kind = k; d_turf = tu; d_thr = th;
  endtask

  task automatic set_ins(logic [AW-1:0] lo, logic [AW-1:0] hi, logic [3:0] p,
                         logic [IW-1:0] tu, logic [IW-1:0] th, bit any, bit nov);
    d_ins = 1; d_lo = lo; d_hi = hi; d_perm = p; d_iturf = tu; d_ithr = th;
    d_any = any; d_novel = nov;
  endtask

  initial begin
    #1_000_000ns;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    d_lk = 0; d_ins = 0; d_rv = 0; d_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1", lk_valid_o, 0); check("R1", stale_count_o, 0);
    check("R1", wb_valid_o, 0); check("R1", ins_done_o, 0); check("R1", ins_reject_o, 0);
    set_lk(32'd0, 2'd0, 22'd0, 22'd0); d_tag = "R1"; tick();

    // R7: first insert into slot 0; R2/R3/R4 around its bounds
    set_ins(32'd100, 32'd199, 4'b0011, 22'd5, 22'd7, 0, 1); tick();
    set_lk(32'd100, 2'd0, 22'd5, 22'd7); tick();               // R2 lower bound
    set_lk(32'd199, 2'd1, 22'd5, 22'd7); tick();               // R2 upper bound
    set_lk(32'd200, 2'd0, 22'd5, 22'd7); tick();               // R4 one past
    set_lk(32'd99,  2'd0, 22'd5, 22'd7); tick();               // R4 one below
    set_lk(32'd150, 2'd2, 22'd5, 22'd7); tick();               // R3 no execute
    set_lk(32'd150, 2'd0, 22'd6, 22'd7); tick();               // R4 other turf
    // R5: any-turf descriptor
    set_ins(32'd300, 32'd300, 4'b0100, 22'd0, 22'd9, 1, 0); tick();
    set_lk(32'd300, 2'd2, 22'd1234, 22'd9); d_tag = "R5"; tick();
    set_lk(32'd300, 2'd2, 22'd1234, 22'd10); d_tag = "R5"; tick();
    // R6: execute plus protected call refused
    set_ins(32'd500, 32'd600, 4'b1100, 22'd1, 22'd1, 0, 1); tick();
    set_lk(32'd550, 2'd2, 22'd1, 22'd1); d_tag = "R6"; tick();
    // R9: clean revoke counts, repeat and novel revoke do not
    d_rv = 1; d_rvidx = 1; tick();
    set_lk(32'd300, 2'd2, 22'd7, 22'd9); d_tag = "R9"; tick();
    d_rv = 1; d_rvidx = 1; tick();
    d_rv = 1; d_rvidx = 0; tick();
    // R10: acknowledge
    d_ack = 1; tick();

    // fill all slots, then R8 evictions
    for (int i = 0; i < N; i++)
      begin set_ins(AW'(i * 64), AW'(i * 64 + 40), 4'b0001, 22'd2, 22'd3, 0, i[0]); tick(); end
    set_ins(32'd2000, 32'd2010, 4'b0011, 22'd2, 22'd3, 0, 1); tick();  // victim 0 clean
    set_ins(32'd2100, 32'd2110, 4'b0011, 22'd2, 22'd3, 0, 1); tick();  // victim 1 novel
    // R11: revoke and insert in one cycle on a full buffer, lookup sees old contents
    d_rv = 1; d_rvidx = 7;
    set_ins(32'd3000, 32'd3050, 4'b0001, 22'd2, 22'd3, 0, 0);
    set_lk(32'd3000, 2'd0, 22'd2, 22'd3); d_tag = "R11"; tick();
    set_lk(32'd3000, 2'd0, 22'd2, 22'd3); d_tag = "R11"; tick();
    d_rv = 1; d_rvidx = 4;
    set_ins(32'd3100, 32'd3150, 4'b0001, 22'd2, 22'd3, 0, 1); d_tag = "R11"; tick();

    // random mix
    for (int it = 0; it < 2000; it++) begin
      int r;
      logic [AW-1:0] lo;
      r = $urandom_range(0, 99);
      set_lk(AW'($urandom_range(0, 2047)), 2'($urandom_range(0, 3)),
             IW'($urandom_range(0, 3)), IW'($urandom_range(0, 3)));
      if (r < 30) begin
        lo = AW'($urandom_range(0, 1900));
        set_ins(lo, lo + AW'($urandom_range(0, 150)), 4'($urandom_range(0, 15)),
                IW'($urandom_range(0, 3)), IW'($urandom_range(0, 3)),
                $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1);
      end
      if (r >= 20 && r < 45) begin d_rv = 1; d_rvidx = $urandom_range(0, N - 1); end
      if (r >= 95) d_ack = 1;
      tick();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule